// File: doc/BRIEF.md
# Pipeline Overflow Exception Squash Controller

This controller sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) and owns the per-stage valid bits. Each cycle the valid bits shift one stage down. A new fetch valid enters at the front. When the execute stage reports an arithmetic overflow or underflow on a valid instruction, the controller squashes that instruction and everything younger than it. It also pulses a redirect to a fixed handler address and loads the faulting PC and a cause code.

The faulting instruction is removed from the pipeline together with the younger ones, so its register write never reaches the register file. The destination it would have overwritten keeps its old value, even when that register is also one of its sources. Older instructions already in the memory and write-back stages carry on unaffected. A taken branch resolved in execute uses the same redirect path but removes only the two younger stages. Memory and register write enables from the datapath pass through the controller and are gated by the owning stage's valid bit.

Top module: `exc_squash_ctrl`

## Requirements
- R1: After reset, all stage valid bits are 0, the exception PC is 0, the cause is 00, and redirect is low.
- R2: When the execute stage is valid and either arithmetic flag is set, flush_o is 5'b00111 (bit 0 fetch, bit 1 decode, bit 2 execute) in that cycle. redirect_o is high and redirect_pc_o equals HANDLER_PC.
- R3: An arithmetic flag raised while the execute stage is invalid is ignored: no flush, no redirect, and the exception PC and cause are unchanged.
- R4: On the edge that takes an exception, epc_o loads ex_pc_i and cause_o loads 01 for overflow or 10 for underflow. When both flags are set, overflow wins.
- R5: In the exception cycle, wb_kill_o is high and kill_dst_o equals ex_dst_i. Two edges later the write-back stage is invalid, so wb_we_o stays low for the faulting instruction.
- R6: flush_o bits 3 (memory) and 4 (write-back) are never set, so older instructions complete.
- R7: A taken branch in a valid execute stage with no exception gives flush_o = 5'b00011, redirect_o high and redirect_pc_o = br_target_i.
- R8: If an exception and a taken branch resolve in the same cycle, the exception wins: flush_o = 5'b00111 and redirect_pc_o = HANDLER_PC.
- R9: On every edge, stage valid bit 0 takes fetch_vld_i. Each later bit takes the bit before it, cleared if that earlier stage was flushed.
- R10: mem_we_o equals mem_we_i when the memory stage is valid and is 0 otherwise. wb_we_o likewise follows wb_we_i gated by the write-back valid bit.
- R11: redirect_o caused by an exception is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_vld_i | input | 1 | A valid instruction enters fetch on the next edge |
| ex_ovf_i | input | 1 | Execute-stage overflow flag |
| ex_unf_i | input | 1 | Execute-stage underflow flag |
| ex_pc_i | input | PC_W | PC of the instruction in execute |
| ex_dst_i | input | REG_W | Destination field of the instruction in execute |
| br_taken_i | input | 1 | Branch in execute resolved taken |
| br_target_i | input | PC_W | Branch target |
| mem_we_i | input | 1 | Store request of the memory-stage instruction |
| wb_we_i | input | 1 | Register write request of the write-back instruction |
| stage_vld_o | output | 5 | Stage valid bits, bit 0 fetch to bit 4 write-back |
| flush_o | output | 5 | Per-stage flush this cycle |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | PC_W | Redirect address |
| wb_kill_o | output | 1 | Faulting instruction's write-back is cancelled |
| kill_dst_o | output | REG_W | Register protected by the cancel |
| mem_we_o | output | 1 | Gated store enable |
| wb_we_o | output | 1 | Gated register write enable |
| epc_o | output | PC_W | Captured exception PC |
| cause_o | output | 2 | Captured cause: 01 overflow, 10 underflow |

## Verification
An arithmetic exception and a taken branch can resolve in the same execute cycle. Both then compete for the flush mask and the redirect address. A pseudo-random sweep raises both flags and the branch with independent probabilities while the pipeline fills and drains, so the collision occurs many times. A bench model computes the expected flush mask, redirect address and valid-bit shift from the requirements, and each cycle's collision is judged against the exception-wins rule. The sweep also puts flags on bubbles and sets both flags together, and the bench checks that the cause encoding and the ignore rule hold in those cases.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned N_STAGE = 5;
  localparam int unsigned S_IF  = 0;
  localparam int unsigned S_ID  = 1;
  localparam int unsigned S_EX  = 2;
  localparam int unsigned S_MEM = 3;
  localparam int unsigned S_WB  = 4;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_OVF  = 2'b01,
    CAUSE_UNF  = 2'b10
  } cause_e;
endpackage

// File: rtl/exc_detect.sv
module exc_detect
  import exc_pkg::*;
(
  input  logic               ex_vld_i,
  input  logic               ovf_i,
  input  logic               unf_i,
  input  logic               br_taken_i,
  output logic               exc_o,
  output logic               br_o,
  output cause_e             cause_o,
  output logic [N_STAGE-1:0] flush_o
);
  assign exc_o   = ex_vld_i & (ovf_i | unf_i);
  assign br_o    = ex_vld_i & br_taken_i & ~exc_o;
  assign cause_o = ovf_i ? CAUSE_OVF : (unf_i ? CAUSE_UNF : CAUSE_NONE);

  // exception kills EX and younger, branch only the younger ones
  for (genvar g = 0; g < N_STAGE; g++) begin : g_flush
    if (g <= S_EX) begin : g_front
      if (g < S_EX) begin : g_young
        assign flush_o[g] = exc_o | br_o;
      end else begin : g_ex
        assign flush_o[g] = exc_o;
      end
    end else begin : g_back
      assign flush_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/exc_valid_pipe.sv
module exc_valid_pipe
  import exc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_vld_i,
  input  logic [N_STAGE-1:0] flush_i,
  output logic [N_STAGE-1:0] vld_o
);
  logic [N_STAGE-1:0] vld_q;

  for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
      end else begin
        if (g == 0) vld_q[g] <= fetch_vld_i;
        else        vld_q[g] <= vld_q[(g == 0) ? 0 : g-1] & ~flush_i[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign vld_o = vld_q;
endmodule

// File: rtl/exc_capture.sv
module exc_capture
  import exc_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic [PC_W-1:0] pc_i,
  input  cause_e          cause_i,
  output logic [PC_W-1:0] epc_o,
  output logic [1:0]      cause_o
);
  logic [PC_W-1:0] epc_q;
  cause_e          cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q   <= '0;
      cause_q <= CAUSE_NONE;
    end else if (take_i) begin
      epc_q   <= pc_i;
      cause_q <= cause_i;
    end
  end

  assign epc_o   = epc_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/exc_squash_ctrl.sv
module exc_squash_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned REG_W      = 5,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_vld_i,
  input  logic               ex_ovf_i,
  input  logic               ex_unf_i,
  input  logic [PC_W-1:0]    ex_pc_i,
  input  logic [REG_W-1:0]   ex_dst_i,
  input  logic               br_taken_i,
  input  logic [PC_W-1:0]    br_target_i,
  input  logic               mem_we_i,
  input  logic               wb_we_i,
  output logic [N_STAGE-1:0] stage_vld_o,
  output logic [N_STAGE-1:0] flush_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic               wb_kill_o,
  output logic [REG_W-1:0]   kill_dst_o,
  output logic               mem_we_o,
  output logic               wb_we_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [1:0]         cause_o
);
  logic               exc;
  logic               br;
  cause_e             cause;
  logic [N_STAGE-1:0] flush;
  logic [N_STAGE-1:0] vld;

  exc_detect u_det (
    .ex_vld_i   (vld[S_EX]),
    .ovf_i      (ex_ovf_i),
    .unf_i      (ex_unf_i),
    .br_taken_i (br_taken_i),
    .exc_o      (exc),
    .br_o       (br),
    .cause_o    (cause),
    .flush_o    (flush)
  );

  exc_valid_pipe u_vld (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_vld_i (fetch_vld_i),
    .flush_i     (flush),
    .vld_o       (vld)
  );

  exc_capture #(.PC_W(PC_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (exc),
    .pc_i    (ex_pc_i),
    .cause_i (cause),
    .epc_o   (epc_o),
    .cause_o (cause_o)
  );

  assign stage_vld_o   = vld;
  assign flush_o       = flush;
  assign redirect_o    = exc | br;
  assign redirect_pc_o = exc ? HANDLER_PC : br_target_i;
  assign wb_kill_o     = exc;
  assign kill_dst_o    = exc ? ex_dst_i : '0;
  assign mem_we_o      = mem_we_i & vld[S_MEM];
  assign wb_we_o       = wb_we_i & vld[S_WB];
endmodule

// File: rtl/exc_squash_chk.sv
module exc_squash_chk #(
  parameter int unsigned PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ex_ovf_i,
  input logic            ex_unf_i,
  input logic [PC_W-1:0] ex_pc_i,
  input logic            br_taken_i,
  input logic [4:0]      stage_vld_o,
  input logic [4:0]      flush_o,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o,
  input logic            wb_kill_o,
  input logic            mem_we_o,
  input logic [PC_W-1:0] epc_o,
  input logic [1:0]      cause_o
);
  a_r2_exc_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld_o[2] && (ex_ovf_i || ex_unf_i)) |-> (flush_o == 5'b00111 && redirect_pc_o == HANDLER_PC));

  a_r8_exc_over_br: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld_o[2] && ex_unf_i && br_taken_i) |-> (redirect_pc_o == HANDLER_PC && wb_kill_o));

  a_r3_bubble_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stage_vld_o[2] |-> (!redirect_o && flush_o == 5'b00000));

  a_r6_older_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o[4:3] == 2'b00);

  a_r4_cause_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld_o[2] && ex_ovf_i) |=> (cause_o == 2'b01 && epc_o == $past(ex_pc_i)));

  a_r5_wb_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_kill_o |=> ##1 !stage_vld_o[4]);

  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o[1] |=> !stage_vld_o[2]);

  a_r10_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stage_vld_o[3] |-> !mem_we_o);

  a_r11_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_kill_o |=> !redirect_o);
endmodule

bind exc_squash_ctrl exc_squash_chk #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ex_ovf_i      (ex_ovf_i),
  .ex_unf_i      (ex_unf_i),
  .ex_pc_i       (ex_pc_i),
  .br_taken_i    (br_taken_i),
  .stage_vld_o   (stage_vld_o),
  .flush_o       (flush_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .wb_kill_o     (wb_kill_o),
  .mem_we_o      (mem_we_o),
  .epc_o         (epc_o),
  .cause_o       (cause_o)
);

// File: tb/sim_exc_squash_ctrl.sv
`timescale 1ns/1ps
module sim_exc_squash_ctrl;
  localparam logic [31:0] HPC = 32'h0000_0180;
  localparam int NCYC = 4000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fetch_vld_i = 1'b0, ex_ovf_i = 1'b0, ex_unf_i = 1'b0, br_taken_i = 1'b0;
  logic mem_we_i = 1'b0, wb_we_i = 1'b0;
  logic [31:0] ex_pc_i = '0, br_target_i = '0;
  logic [4:0]  ex_dst_i = '0;
  logic [4:0]  stage_vld_o, flush_o, kill_dst_o;
  logic        redirect_o, wb_kill_o, mem_we_o, wb_we_o;
  logic [31:0] redirect_pc_o, epc_o;
  logic [1:0]  cause_o;

  int total = 0, bad = 0;
  bit done = 0;
  int n_col = 0, n_both = 0, n_bub = 0;

  always #2.5 clk_i = ~clk_i;

  exc_squash_ctrl #(.PC_W(32), .REG_W(5), .HANDLER_PC(HPC)) u0 (
    .clk_i, .rst_ni, .fetch_vld_i, .ex_ovf_i, .ex_unf_i, .ex_pc_i, .ex_dst_i,
    .br_taken_i, .br_target_i, .mem_we_i, .wb_we_i, .stage_vld_o, .flush_o,
    .redirect_o, .redirect_pc_o, .wb_kill_o, .kill_dst_o, .mem_we_o, .wb_we_o,
    .epc_o, .cause_o
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    logic [4:0]  m_vld;
    logic [31:0] m_epc;
    logic [1:0]  m_cause;
    logic [31:0] x;
    logic        prev_exc;
    m_vld = '0; m_epc = '0; m_cause = 2'b00; x = 32'h1234_5677; prev_exc = 1'b0;

    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #1;
    chk("R1 stage_vld", 64'(stage_vld_o), 64'(0));
    chk("R1 epc", 64'(epc_o), 64'(0));
    chk("R1 cause", 64'(cause_o), 64'(0));
    chk("R1 redirect", 64'(redirect_o), 64'(0));
    rst_ni = 1'b1;

    for (int c = 0; c < NCYC; c++) begin
      logic exc, br, flag;
      logic [4:0] fl, nv;
      string ft;
      @(negedge clk_i);
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      fetch_vld_i = x[0] | x[1];
      ex_ovf_i    = x[2] & x[3] & x[4];
      ex_unf_i    = x[5] & x[6] & x[7];
      br_taken_i  = x[8] & x[9];
      mem_we_i    = x[10];
      wb_we_i     = x[11];
      ex_dst_i    = x[16:12];
      ex_pc_i     = {x[15:0], x[31:16]};
      br_target_i = ~x;
      #1;
      flag = ex_ovf_i | ex_unf_i;
      exc  = m_vld[2] & flag;
      br   = m_vld[2] & br_taken_i & ~exc;
      fl   = exc ? 5'b00111 : (br ? 5'b00011 : 5'b00000);
      if (exc && br_taken_i) n_col++;
      if (exc && ex_ovf_i && ex_unf_i) n_both++;
      if (!m_vld[2] && flag) n_bub++;
      ft = (exc && br_taken_i) ? "R8 flush" : exc ? "R2 flush" : br ? "R7 flush" : "R3 flush";
      chk("R9 stage_vld", 64'(stage_vld_o), 64'(m_vld));
      chk(ft, 64'(flush_o), 64'(fl));
      chk("R6 older", 64'(flush_o[4:3]), 64'(0));
      chk(prev_exc ? "R11 redirect" : (exc ? "R2 redirect" : "R3 redirect"),
          64'(redirect_o), 64'(exc | br));
      if (exc | br)
        chk(exc ? ((br_taken_i) ? "R8 redirect_pc" : "R2 redirect_pc") : "R7 redirect_pc",
            64'(redirect_pc_o), exc ? 64'(HPC) : 64'(br_target_i));
      chk("R5 wb_kill", 64'(wb_kill_o), 64'(exc));
      if (exc) chk("R5 kill_dst", 64'(kill_dst_o), 64'(ex_dst_i));
      chk("R10 mem_we", 64'(mem_we_o), 64'(mem_we_i & m_vld[3]));
      chk("R5 wb_we", 64'(wb_we_o), 64'(wb_we_i & m_vld[4]));
      chk(flag && !m_vld[2] ? "R3 epc" : "R4 epc", 64'(epc_o), 64'(m_epc));
      chk(flag && !m_vld[2] ? "R3 cause" : "R4 cause", 64'(cause_o), 64'(m_cause));
      nv[0] = fetch_vld_i;
      for (int s = 1; s < 5; s++) nv[s] = m_vld[s-1] & ~fl[s-1];
      m_vld = nv;
      if (exc) begin
        m_epc   = ex_pc_i;
        m_cause = ex_ovf_i ? 2'b01 : 2'b10;
      end
      prev_exc = exc;
    end

    chk("R8 collision seen", 64'(n_col > 0), 64'(1));
    chk("R4 both flags seen", 64'(n_both > 0), 64'(1));
    chk("R3 bubble flag seen", 64'(n_bub > 0), 64'(1));
    done = 1;
    finish_run();
  end
endmodule